// File: doc/BRIEF.md
# Auto-Incrementing Host Memory Access Port

This block is a slave port that lets an outside device, running on its own timing, reach a processor's on-chip program and data memories. Address and data share one 16-bit bus. The host first loads a control word. Depending on its top bit, that word is either a start location plus a memory-space choice, or an overlay page number. The host then issues a run of read or write strobes. After each completed access the location advances by itself, so a block of memory moves after a single address load.

Host strobes arrive with no relation to the core clock. Each strobe is brought into the core domain through a two-stage synchronizer and detected by its edge. The port then spends one core cycle performing the request, and it signals completion on an acknowledge line. Program words are 24 bits wide and are moved as two host transfers. The control word can also be written from the core side at one fixed data address. A malformed overlay word is dropped and sets a sticky error flag. The memories in the block are small behavioural RAM models indexed by the low bits of the 14-bit location counter.

Top module: `hostmem_port`

## Requirements
- R1: A control word with bit 15 = 0 loads bits 13:0 as the location counter and bit 14 as the space (1 = program memory, 0 = data memory); the overlay page and error flag are left unchanged.
- R2: A control word with bit 15 = 1 and bits 14:8 all zero sets `ovl_page` to bits 7:0 and leaves the location counter and space untouched.
- R3: A control word with bit 15 = 1 and any of bits 14:8 set changes neither the page, the location nor the space, and sets `cw_err`, which stays set until reset.
- R4: A control word is taken from `h_ad_in` when `h_latch` falls while `h_sel` has been held high.
- R5: In data space each read returns the 16-bit word at the current location, each write stores `h_ad_in` there, and the location then increments by one.
- R6: In program space, the first transfer of a pair carries bits 23:8 and the second carries bits 7:0 on bus bits 7:0 (a second read returns zeros in bits 15:8). The location increments only after the second transfer, and loading an address control word restarts the pair at the first half.
- R7: A read always returns memory contents and never the location counter.
- R8: The location counter is 14 bits wide and wraps from 0x3FFF to 0x0000.
- R9: `h_ack` is high after reset and between requests. With a strobe change just before rising clock edge P0, `h_ack` is low from edge P2 to edge P3, and read data on `h_ad_out` is valid once `h_ack` is high again.
- R10: A core write with `core_addr` = 0x3FE0 loads `core_wdata` as a control word with the same decoding, unless a host access is in progress in that cycle. Writes to any other address have no effect.
- R11: Read, write and latch strobes given while `h_sel` is low are ignored: `h_ack` stays high and the location does not move.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| h_sel | input | 1 | Host port select, active high |
| h_latch | input | 1 | Host control-word latch strobe; falling edge loads |
| h_rd | input | 1 | Host read strobe; rising edge requests |
| h_wr | input | 1 | Host write strobe; rising edge requests |
| h_ad_in | input | 16 | Host bus, inbound (control word or write data) |
| h_ad_out | output | 16 | Host bus, outbound read data |
| h_ad_oe | output | 1 | Drive enable for the outbound bus (select and read) |
| h_ack | output | 1 | Acknowledge; low while a request is being performed |
| core_we | input | 1 | Core-side write enable |
| core_addr | input | 14 | Core-side data address |
| core_wdata | input | 16 | Core-side write data |
| ovl_page | output | 8 | Current overlay page |
| cw_err | output | 1 | Sticky malformed-control-word flag |

## Verification
The memories are swept in full, in both spaces, with location-dependent patterns that differ between data and program space. Reading them back after both fills shows whether the auto-increment, the split of program words into halves and the separation of the spaces are right. Control words are applied in each of their three forms: a set of page values, a single-bit sweep across bits 14:8 for the malformed form, and start addresses that sit in the middle of memory or at the top of the counter range. These patterns show whether a word is routed to the page or to the counter, and whether the counter wraps. Every host request also checks the acknowledge shape cycle by cycle. Further checks cover core-side loads at the fixed address and at a neighbouring address, and strobes given with the port deselected.

// File: rtl/hmp_pkg.sv
package hmp_pkg;

  localparam int unsigned BUS_W  = 16;
  localparam int unsigned LOC_W  = 14;
  localparam int unsigned PAGE_W = 8;
  localparam int unsigned PW_W   = 24;

  typedef enum logic [1:0] {
    REQ_LOAD = 2'd0,
    REQ_RD   = 2'd1,
    REQ_WR   = 2'd2
  } req_e;

  typedef enum logic [1:0] {
    CW_LOC  = 2'd0,
    CW_PAGE = 2'd1,
    CW_BAD  = 2'd2
  } cw_kind_e;

  typedef struct packed {
    cw_kind_e           kind;
    logic               prog;
    logic [LOC_W-1:0]   loc;
    logic [PAGE_W-1:0]  page;
  } cw_t;

  function automatic cw_t cw_decode(input logic [BUS_W-1:0] w);
    cw_t r;
    r.prog = w[14];
    r.loc  = w[LOC_W-1:0];
    r.page = w[PAGE_W-1:0];
    if (!w[15])              r.kind = CW_LOC;
    else if (w[14:8] == '0)  r.kind = CW_PAGE;
    else                     r.kind = CW_BAD;
    return r;
  endfunction

endpackage

// File: rtl/hmp_sync.sv
module hmp_sync #(
  parameter int unsigned N = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] raw,
  output logic [N-1:0] lvl,
  output logic [N-1:0] lvl_q
);

  for (genvar i = 0; i < N; i++) begin : g_bit
    logic st1, st2, st3;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        st1 <= 1'b0;
        st2 <= 1'b0;
        st3 <= 1'b0;
      end else begin
        st1 <= raw[i];
        st2 <= st1;
        st3 <= st2;
      end
    end
    assign lvl[i]   = st2;
    assign lvl_q[i] = st3;
  end

endmodule

// File: rtl/hmp_ram.sv
module hmp_ram #(
  parameter int unsigned W  = 16,
  parameter int unsigned AW = 6
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] addr,
  input  logic [W-1:0]  wdata,
  output logic [W-1:0]  rdata
);

  localparam int unsigned DEPTH = 1 << AW;

  logic [W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[addr] <= wdata;
  end

  assign rdata = mem[addr];

endmodule

// File: rtl/hmp_ctrl.sv
module hmp_ctrl
  import hmp_pkg::*;
#(
  parameter int unsigned    RAM_AW   = 6,
  parameter logic [LOC_W-1:0] CFG_ADDR = 14'h3FE0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ev_load,
  input  logic              ev_rd,
  input  logic              ev_wr,
  input  logic [BUS_W-1:0]  bus_in,
  input  logic              core_we,
  input  logic [LOC_W-1:0]  core_addr,
  input  logic [BUS_W-1:0]  core_wdata,
  output logic              busy,
  output logic [BUS_W-1:0]  rdata,
  output logic [PAGE_W-1:0] page,
  output logic              err,
  output logic              pm_we,
  output logic              dm_we,
  output logic [RAM_AW-1:0] mem_addr,
  output logic [PW_W-1:0]   pm_wdata,
  output logic [BUS_W-1:0]  dm_wdata,
  input  logic [PW_W-1:0]   pm_rdata,
  input  logic [BUS_W-1:0]  dm_rdata
);

  logic               op_q,    op_n;
  req_e               kind_q,  kind_n;
  logic [BUS_W-1:0]   word_q,  word_n;
  logic [LOC_W-1:0]   loc_q,   loc_n;
  logic               prog_q,  prog_n;
  logic               half_q,  half_n;
  logic [PAGE_W-1:0]  page_q,  page_n;
  logic               err_q,   err_n;
  logic [BUS_W-1:0]   hold_q,  hold_n;
  logic [BUS_W-1:0]   rdata_q, rdata_n;
  logic               cw_app;
  logic [BUS_W-1:0]   cw_word;
  cw_t                cw;

  always_comb begin
    op_n    = 1'b0;
    kind_n  = kind_q;
    word_n  = word_q;
    loc_n   = loc_q;
    prog_n  = prog_q;
    half_n  = half_q;
    page_n  = page_q;
    err_n   = err_q;
    hold_n  = hold_q;
    rdata_n = rdata_q;
    pm_we   = 1'b0;
    dm_we   = 1'b0;
    cw_app  = 1'b0;
    cw_word = '0;

    if (!op_q && (ev_load || ev_wr || ev_rd)) begin
      op_n   = 1'b1;
      word_n = bus_in;
      kind_n = ev_load ? REQ_LOAD : (ev_wr ? REQ_WR : REQ_RD);
    end

    if (op_q) begin
      case (kind_q)
        REQ_LOAD: begin
          cw_app  = 1'b1;
          cw_word = word_q;
        end
        REQ_WR: begin
          if (prog_q) begin
            if (!half_q) begin
              hold_n = word_q;
              half_n = 1'b1;
            end else begin
              pm_we  = 1'b1;
              half_n = 1'b0;
              loc_n  = loc_q + 1'b1;
            end
          end else begin
            dm_we = 1'b1;
            loc_n = loc_q + 1'b1;
          end
        end
        default: begin
          if (prog_q) begin
            rdata_n = half_q ? {8'h00, pm_rdata[7:0]} : pm_rdata[PW_W-1:8];
            half_n  = ~half_q;
            if (half_q) loc_n = loc_q + 1'b1;
          end else begin
            rdata_n = dm_rdata;
            loc_n   = loc_q + 1'b1;
          end
        end
      endcase
    end else if (core_we && core_addr == CFG_ADDR) begin
      cw_app  = 1'b1;
      cw_word = core_wdata;
    end

    cw = cw_decode(cw_word);
    if (cw_app) begin
      case (cw.kind)
        CW_LOC: begin
          loc_n  = cw.loc;
          prog_n = cw.prog;
          half_n = 1'b0;
        end
        CW_PAGE: page_n = cw.page;
        default: err_n  = 1'b1;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      op_q    <= 1'b0;
      kind_q  <= REQ_LOAD;
      word_q  <= '0;
      loc_q   <= '0;
      prog_q  <= 1'b0;
      half_q  <= 1'b0;
      page_q  <= '0;
      err_q   <= 1'b0;
      hold_q  <= '0;
      rdata_q <= '0;
    end else begin
      op_q    <= op_n;
      kind_q  <= kind_n;
      word_q  <= word_n;
      loc_q   <= loc_n;
      prog_q  <= prog_n;
      half_q  <= half_n;
      page_q  <= page_n;
      err_q   <= err_n;
      hold_q  <= hold_n;
      rdata_q <= rdata_n;
    end
  end

  assign busy     = op_q;
  assign rdata    = rdata_q;
  assign page     = page_q;
  assign err      = err_q;
  assign mem_addr = loc_q[RAM_AW-1:0];
  assign pm_wdata = {hold_q, word_q[7:0]};
  assign dm_wdata = word_q;

  AST_ACCESS_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    op_q |=> !op_q); // R9
  AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    err_q |=> err_q); // R3
  AST_BAD_WORD_DROPPED: assert property (@(posedge clk) disable iff (!rst_n)
    (cw_app && cw.kind == CW_BAD) |=> ($stable(loc_q) && $stable(page_q) && $stable(prog_q))); // R3
  AST_PAGE_ONLY_BY_WORD: assert property (@(posedge clk) disable iff (!rst_n)
    !(cw_app && cw.kind == CW_PAGE) |=> $stable(page_q)); // R2
  AST_DATA_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (op_q && kind_q != REQ_LOAD && !prog_q) |=> loc_q == LOC_W'($past(loc_q) + 1'b1)); // R5
  AST_PROG_FIRST_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (op_q && kind_q != REQ_LOAD && prog_q && !half_q) |=> $stable(loc_q)); // R6
  AST_PROG_SECOND_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (op_q && kind_q != REQ_LOAD && prog_q && half_q) |=> loc_q == LOC_W'($past(loc_q) + 1'b1)); // R6

endmodule

// File: rtl/hostmem_port.sv
module hostmem_port
  import hmp_pkg::*;
#(
  parameter int unsigned RAM_AW = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              h_sel,
  input  logic              h_latch,
  input  logic              h_rd,
  input  logic              h_wr,
  input  logic [BUS_W-1:0]  h_ad_in,
  output logic [BUS_W-1:0]  h_ad_out,
  output logic              h_ad_oe,
  output logic              h_ack,
  input  logic              core_we,
  input  logic [LOC_W-1:0]  core_addr,
  input  logic [BUS_W-1:0]  core_wdata,
  output logic [PAGE_W-1:0] ovl_page,
  output logic              cw_err
);

  localparam int unsigned I_SEL = 0;
  localparam int unsigned I_LAT = 1;
  localparam int unsigned I_RD  = 2;
  localparam int unsigned I_WR  = 3;
  localparam int unsigned N_STB = 4;

  logic              rst_m, rst_s;
  logic [N_STB-1:0]  lvl, lvl_q;
  logic              sel_ok, ev_load, ev_rd, ev_wr, busy;
  logic              pm_we, dm_we;
  logic [RAM_AW-1:0] mem_addr;
  logic [PW_W-1:0]   pm_wdata, pm_rdata;
  logic [BUS_W-1:0]  dm_wdata, dm_rdata;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_m <= 1'b0;
      rst_s <= 1'b0;
    end else begin
      rst_m <= 1'b1;
      rst_s <= rst_m;
    end
  end

  hmp_sync #(.N(N_STB)) u_sync (
    .clk   (clk),
    .rst_n (rst_s),
    .raw   ({h_wr, h_rd, h_latch, h_sel}),
    .lvl   (lvl),
    .lvl_q (lvl_q)
  );

  assign sel_ok  = lvl[I_SEL] & lvl_q[I_SEL];
  assign ev_load = sel_ok & ~lvl[I_LAT] & lvl_q[I_LAT];
  assign ev_rd   = sel_ok &  lvl[I_RD]  & ~lvl_q[I_RD] & ~lvl[I_LAT];
  assign ev_wr   = sel_ok &  lvl[I_WR]  & ~lvl_q[I_WR] & ~lvl[I_LAT];

  hmp_ctrl #(.RAM_AW(RAM_AW)) u_ctrl (
    .clk        (clk),
    .rst_n      (rst_s),
    .ev_load    (ev_load),
    .ev_rd      (ev_rd),
    .ev_wr      (ev_wr),
    .bus_in     (h_ad_in),
    .core_we    (core_we),
    .core_addr  (core_addr),
    .core_wdata (core_wdata),
    .busy       (busy),
    .rdata      (h_ad_out),
    .page       (ovl_page),
    .err        (cw_err),
    .pm_we      (pm_we),
    .dm_we      (dm_we),
    .mem_addr   (mem_addr),
    .pm_wdata   (pm_wdata),
    .dm_wdata   (dm_wdata),
    .pm_rdata   (pm_rdata),
    .dm_rdata   (dm_rdata)
  );

  hmp_ram #(.W(PW_W), .AW(RAM_AW)) u_pm (
    .clk   (clk),
    .we    (pm_we),
    .addr  (mem_addr),
    .wdata (pm_wdata),
    .rdata (pm_rdata)
  );

  hmp_ram #(.W(BUS_W), .AW(RAM_AW)) u_dm (
    .clk   (clk),
    .we    (dm_we),
    .addr  (mem_addr),
    .wdata (dm_wdata),
    .rdata (dm_rdata)
  );

  assign h_ack   = ~busy;
  assign h_ad_oe = h_sel & h_rd;

  AST_NO_DOUBLE_WRITE: assert property (@(posedge clk) disable iff (!rst_s)
    !(pm_we && dm_we)); // R1
  AST_DESELECT_QUIET: assert property (@(posedge clk) disable iff (!rst_s)
    !lvl[I_SEL] |=> h_ack); // R11

endmodule

// File: tb/hostmem_port_bench.sv
module hostmem_port_bench;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        h_sel, h_latch, h_rd, h_wr;
  logic [15:0] h_ad_in;
  logic [15:0] h_ad_out;
  logic        h_ad_oe, h_ack;
  logic        core_we;
  logic [13:0] core_addr;
  logic [15:0] core_wdata;
  logic [7:0]  ovl_page;
  logic        cw_err;

  int checks = 0;
  int errors = 0;

  always #2.5 clk = ~clk;

  hostmem_port u_hostmem_port (
    .clk(clk), .rst_n(rst_n), .h_sel(h_sel), .h_latch(h_latch), .h_rd(h_rd),
    .h_wr(h_wr), .h_ad_in(h_ad_in), .h_ad_out(h_ad_out), .h_ad_oe(h_ad_oe),
    .h_ack(h_ack), .core_we(core_we), .core_addr(core_addr),
    .core_wdata(core_wdata), .ovl_page(ovl_page), .cw_err(cw_err)
  );

  function automatic logic [15:0] dmv(input int i);
    return 16'((i * 16'h0A73) ^ 16'h5C3E);
  endfunction

  function automatic logic [23:0] pmv(input int i);
    return 24'((i * 24'h01F3B5) ^ 24'hA50C3D);
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // R9: ack high at N1 and N2, low at N3, high again at N4
  task automatic ack_seq(input string req);
    logic [3:0] seen;
    for (int k = 0; k < 4; k++) begin
      @(negedge clk);
      seen[k] = h_ack;
    end
    chk({req, " R9 ack shape"}, {28'h0, seen}, 32'h0000000B);
  endtask

  task automatic host_load(input logic [15:0] w, input string req);
    h_ad_in = w;
    h_sel = 1'b1;
    @(negedge clk);
    h_latch = 1'b1;
    repeat (3) @(negedge clk);
    h_latch = 1'b0;
    ack_seq({req, " R4 load"});
    h_sel = 1'b0;
    repeat (3) @(negedge clk);
  endtask

  task automatic host_read(output logic [15:0] d, input string req);
    h_sel = 1'b1;
    @(negedge clk);
    h_rd = 1'b1;
    ack_seq(req);
    d = h_ad_out;
    chk({req, " R9 oe"}, {31'h0, h_ad_oe}, 32'h1);
    h_rd = 1'b0;
    @(negedge clk);
    h_sel = 1'b0;
    repeat (3) @(negedge clk);
  endtask

  task automatic host_write(input logic [15:0] d, input string req);
    h_ad_in = d;
    h_sel = 1'b1;
    @(negedge clk);
    h_wr = 1'b1;
    ack_seq(req);
    h_wr = 1'b0;
    @(negedge clk);
    h_sel = 1'b0;
    repeat (3) @(negedge clk);
  endtask

  task automatic core_write(input logic [13:0] a, input logic [15:0] d);
    core_addr = a;
    core_wdata = d;
    core_we = 1'b1;
    @(negedge clk);
    core_we = 1'b0;
    @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [15:0] d;
    logic [23:0] pw;
    logic [7:0]  pages [4];
    pages[0] = 8'h01; pages[1] = 8'h5A; pages[2] = 8'hFF; pages[3] = 8'h00;

    rst_n = 1'b0; h_sel = 1'b0; h_latch = 1'b0; h_rd = 1'b0; h_wr = 1'b0;
    h_ad_in = '0; core_we = 1'b0; core_addr = '0; core_wdata = '0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    chk("R9 reset ack", {31'h0, h_ack}, 32'h1);
    chk("R2 reset page", {24'h0, ovl_page}, 32'h0);
    chk("R3 reset err", {31'h0, cw_err}, 32'h0);
    chk("R9 reset oe", {31'h0, h_ad_oe}, 32'h0);

    // R5: full data-space fill and readback by auto-increment
    host_load(16'h0000, "R1");
    for (int i = 0; i < 64; i++) host_write(dmv(i), "R5 dm wr");
    // R6: full program-space fill, two transfers per word
    host_load(16'h4000, "R1");
    for (int i = 0; i < 64; i++) begin
      pw = pmv(i);
      host_write(pw[23:8], "R6 pm wr hi");
      host_write({8'hC3, pw[7:0]}, "R6 pm wr lo");
    end
    host_load(16'h0000, "R1");
    for (int i = 0; i < 64; i++) begin
      host_read(d, "R5 dm rd");
      chk("R5 dm data", {16'h0, d}, {16'h0, dmv(i)});
    end
    host_load(16'h4000, "R1");
    for (int i = 0; i < 64; i++) begin
      pw = pmv(i);
      host_read(d, "R6 pm rd hi");
      chk("R6 pm high", {16'h0, d}, {16'h0, pw[23:8]});
      host_read(d, "R6 pm rd lo");
      chk("R6 pm low", {16'h0, d}, {24'h0, pw[7:0]});
    end

    // R7: read returns memory, not the loaded location
    host_load(16'h0012, "R7");
    host_read(d, "R7");
    chk("R7 data not address", {16'h0, d}, {16'h0, dmv(18)});

    // R6: reload restarts the pair; mid-range start
    host_load(16'h4005, "R6");
    host_read(d, "R6");
    chk("R6 first half", {16'h0, d}, {16'h0, pmv(5)} >> 8);
    host_load(16'h4005, "R6");
    host_read(d, "R6");
    chk("R6 restart high", {16'h0, d}, {16'h0, pmv(5)} >> 8);
    host_read(d, "R6");
    chk("R6 restart low", {16'h0, d}, {24'h0, pmv(5)} & 32'hFF);
    host_read(d, "R6");
    chk("R6 next word", {16'h0, d}, {16'h0, pmv(6)} >> 8);

    // R2: page words do not move the location
    host_load(16'h0010, "R2");
    for (int p = 0; p < 4; p++) begin
      host_load(16'h8000 | {8'h00, pages[p]}, "R2");
      chk("R2 page", {24'h0, ovl_page}, {24'h0, pages[p]});
    end
    host_read(d, "R2");
    chk("R2 location kept", {16'h0, d}, {16'h0, dmv(16)});

    // R3: malformed page words, one stray bit each in 14:8
    chk("R3 err before", {31'h0, cw_err}, 32'h0);
    for (int b = 8; b < 15; b++) begin
      host_load(16'h8000 | (16'h1 << b) | 16'h003C, "R3");
      chk("R3 page kept", {24'h0, ovl_page}, 32'h0);
      chk("R3 err set", {31'h0, cw_err}, 32'h1);
    end
    host_read(d, "R3");
    chk("R3 location kept", {16'h0, d}, {16'h0, dmv(17)});

    // R8: wrap at the top of the counter
    host_load(16'h3FFF, "R8");
    host_write(16'h1234, "R8");
    host_write(16'h5678, "R8");
    host_load(16'h0000, "R8");
    host_read(d, "R8");
    chk("R8 after wrap", {16'h0, d}, 32'h5678);
    host_load(16'h003F, "R8");
    host_read(d, "R8");
    chk("R8 top word", {16'h0, d}, 32'h1234);

    // R10: core-side control word
    core_write(14'h3FE0, 16'h8042);
    chk("R10 core page", {24'h0, ovl_page}, 32'h42);
    core_write(14'h3FE1, 16'h8099);
    chk("R10 other address", {24'h0, ovl_page}, 32'h42);
    core_write(14'h3FE0, 16'h0020);
    host_read(d, "R10");
    chk("R10 core location", {16'h0, d}, {16'h0, dmv(32)});
    core_write(14'h3FE0, 16'h4003);
    host_read(d, "R10");
    chk("R10 core prog", {16'h0, d}, {16'h0, pmv(3)} >> 8);
    chk("R10 err still set", {31'h0, cw_err}, 32'h1);

    // R11: strobes while deselected
    host_load(16'h0008, "R11");
    h_ad_in = 16'hDEAD;
    h_rd = 1'b1;
    for (int k = 0; k < 4; k++) begin
      @(negedge clk);
      chk("R11 ack idle rd", {31'h0, h_ack}, 32'h1);
    end
    chk("R11 oe off", {31'h0, h_ad_oe}, 32'h0);
    h_rd = 1'b0;
    repeat (3) @(negedge clk);
    h_wr = 1'b1;
    for (int k = 0; k < 4; k++) begin
      @(negedge clk);
      chk("R11 ack idle wr", {31'h0, h_ack}, 32'h1);
    end
    h_wr = 1'b0;
    h_latch = 1'b1;
    repeat (3) @(negedge clk);
    h_latch = 1'b0;
    repeat (4) @(negedge clk);
    host_read(d, "R11");
    chk("R11 location kept", {16'h0, d}, {16'h0, dmv(8)});
    host_read(d, "R11");
    chk("R11 no stray write", {16'h0, d}, {16'h0, dmv(9)});

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule